// File: doc/BRIEF.md
# Audio Sample Rate Generator

This block produces the bit clock and the frame sync of a serial audio port when the port drives its own clocks. A programmable divider turns the system clock into a bit clock. A frame counter then counts rising bit clock edges and raises the frame sync for a programmable number of bit clocks at the start of every frame. A one-cycle frame-start strobe, in the system clock domain, marks the bit clock edge on which each frame begins, so nearby logic can align sample words without detecting edges itself.

Software chooses the frame shape by how it programs the fields. A width of half the frame gives a 50 % duty frame sync, which suits left/right stereo formats. A width field of zero gives a one-bit pulse, which suits the DSP-style short-sync formats. Before it runs, the block checks that the configuration makes sense: the sync must be shorter than the frame, and the frame must hold every bit of every channel. A configuration that fails either test raises an error and produces no clocks.

A three-state controller governs the generator. In IDLE the outputs are quiet. It moves to RUN when enable is high and the configuration is valid, and to FAULT when enable is high and the configuration is invalid. RUN returns to IDLE when enable falls and goes to FAULT if the configuration becomes invalid. FAULT returns to IDLE when enable falls. Only RUN lets the divider and the frame counter advance. In the other two states both are held at the start of a frame.

Top module: `audio_srg`

## Requirements
- R1: Each bit clock half period lasts cfg_div+1 system clock cycles, so a field value of 0 gives half the system clock rate. bclk goes high for the first time cfg_div+1 cycles after the clock edge on which RUN is entered.
- R2: A frame is cfg_period+1 bit clocks long. Bit positions are counted from 0 at the first rising bit clock edge of the frame. The frame sync is active at positions 0 to cfg_width and changes only on a rising bit clock edge.
- R3: A width field of 0 gives a sync exactly one bit clock long. A width field of (cfg_period+1)/2-1 gives a sync lasting half the frame.
- R4: When cfg_fs_invert is 1, fsync is the logical inverse of its non-inverted value. bclk and frame_start are the same for both polarities.
- R5: frame_start is high for exactly one system clock cycle, in the cycle in which bclk goes high at bit position 0. No other cycle raises it.
- R6: When enable is low, from the second clock edge on, bclk is 0, fsync is at its inactive level and frame_start is 0. After enable rises again, the generator starts a fresh frame at position 0.
- R7: cfg_err is 1 whenever cfg_width is greater than or equal to cfg_period. The generator then produces no bit clock and no frame start.
- R8: cfg_err is 1 whenever cfg_period+1 is less than cfg_word_bits times cfg_chans. A frame exactly equal to that product is accepted and runs.
- R9: While reset is asserted, bclk and frame_start are 0 and fsync is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| enable | input | 1 | run request |
| cfg_div | input | DIV_W | bit clock half period minus one, in system clocks |
| cfg_period | input | PER_W | bit clocks per frame minus one |
| cfg_width | input | WID_W | frame sync length minus one, in bit clocks |
| cfg_word_bits | input | WB_W | bits per channel word |
| cfg_chans | input | CH_W | channels per frame |
| cfg_fs_invert | input | 1 | 1 selects an active-low frame sync |
| bclk | output | 1 | bit clock |
| fsync | output | 1 | frame sync |
| frame_start | output | 1 | one-cycle strobe at the first bit clock of a frame |
| cfg_err | output | 1 | configuration is invalid |

## Verification
The bench works through every divisor, period, width and polarity in a small range and predicts each output in every cycle from the elapsed cycle count. Several kinds of bug would break that prediction. An off-by-one in the divide ratio stretches every bit clock. A divisor of zero that stalls gives no clock at all. A sync compare of less-than instead of less-or-equal makes every sync one bit short, and width-zero frames lose their pulse entirely. A counter that is not cleared when enable falls restarts in the middle of a frame. The error boundaries are probed at both edges: width equal to the period, and a frame exactly as large as, or one bit smaller than, the word and channel product. An error compare that is off by one would either run an illegal frame or reject a legal one.

// File: rtl/srg_pkg.sv
package srg_pkg;
    typedef enum logic [1:0] {
        SRG_IDLE  = 2'd0,
        SRG_RUN   = 2'd1,
        SRG_FAULT = 2'd2
    } srg_state_e;
endpackage

// File: rtl/srg_bclk_div.sv
// Bit clock divider: toggles bclk every DIV+1 system clocks while run is high.
module srg_bclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             bclk,
    output logic             rise_now
);
    logic [DIV_W-1:0] cnt;
    logic             terminal;

    always_comb begin
        terminal = (cnt == div);
        rise_now = run && terminal && !bclk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (!run) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (terminal) begin
            cnt  <= '0;
            bclk <= ~bclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/srg_frame_cnt.sv
// Frame counter: advances one bit position per rising bit clock edge.
module srg_frame_cnt #(
    parameter int PER_W = 12,
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             rise_now,
    input  logic [PER_W-1:0] period,
    input  logic [WID_W-1:0] width,
    output logic             fs_act,
    output logic             frame_start
);
    logic             started;
    logic [PER_W-1:0] pos;
    logic [PER_W-1:0] next_pos;
    logic [PER_W-1:0] width_ext;

    always_comb begin
        width_ext = PER_W'(width);
        if (!started || pos == period) next_pos = '0;
        else                           next_pos = pos + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started     <= 1'b0;
            pos         <= '0;
            fs_act      <= 1'b0;
            frame_start <= 1'b0;
        end else if (!run) begin
            started     <= 1'b0;
            pos         <= '0;
            fs_act      <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            frame_start <= 1'b0;
            if (rise_now) begin
                started     <= 1'b1;
                pos         <= next_pos;
                fs_act      <= (next_pos <= width_ext);
                frame_start <= (next_pos == '0);
            end
        end
    end
endmodule

// File: rtl/srg_cfg_check.sv
// Configuration sanity: sync shorter than frame, frame large enough for data.
module srg_cfg_check #(
    parameter int PER_W = 12,
    parameter int WID_W = 8,
    parameter int WB_W  = 6,
    parameter int CH_W  = 4
) (
    input  logic [PER_W-1:0] period,
    input  logic [WID_W-1:0] width,
    input  logic [WB_W-1:0]  word_bits,
    input  logic [CH_W-1:0]  chans,
    output logic             bad
);
    logic [31:0] frame_bits;
    logic [31:0] need_bits;
    logic        sync_too_long;
    logic        frame_too_small;

    always_comb begin
        frame_bits      = 32'(period) + 32'd1;
        need_bits       = 32'(word_bits) * 32'(chans);
        sync_too_long   = (32'(width) >= 32'(period));
        frame_too_small = (frame_bits < need_bits);
        bad             = sync_too_long || frame_too_small;
    end
endmodule

// File: rtl/audio_srg.sv
module audio_srg
    import srg_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PER_W = 12,
    parameter int WID_W = 8,
    parameter int WB_W  = 6,
    parameter int CH_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [PER_W-1:0] cfg_period,
    input  logic [WID_W-1:0] cfg_width,
    input  logic [WB_W-1:0]  cfg_word_bits,
    input  logic [CH_W-1:0]  cfg_chans,
    input  logic             cfg_fs_invert,
    output logic             bclk,
    output logic             fsync,
    output logic             frame_start,
    output logic             cfg_err
);
    srg_state_e state, state_nxt;
    logic       run;
    logic       rise_now;
    logic       fs_act;

    srg_cfg_check #(.PER_W(PER_W), .WID_W(WID_W), .WB_W(WB_W), .CH_W(CH_W)) u_check (
        .period    (cfg_period),
        .width     (cfg_width),
        .word_bits (cfg_word_bits),
        .chans     (cfg_chans),
        .bad       (cfg_err)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            SRG_IDLE: begin
                if (enable && cfg_err)       state_nxt = SRG_FAULT;
                else if (enable)             state_nxt = SRG_RUN;
            end
            SRG_RUN: begin
                if (!enable)                 state_nxt = SRG_IDLE;
                else if (cfg_err)            state_nxt = SRG_FAULT;
            end
            SRG_FAULT: begin
                if (!enable)                 state_nxt = SRG_IDLE;
            end
            default:                         state_nxt = SRG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SRG_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            SRG_RUN:  run = 1'b1;
            SRG_IDLE: run = 1'b0;
            default:  run = 1'b0;
        endcase
    end

    srg_bclk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div      (cfg_div),
        .bclk     (bclk),
        .rise_now (rise_now)
    );

    srg_frame_cnt #(.PER_W(PER_W), .WID_W(WID_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .rise_now    (rise_now),
        .period      (cfg_period),
        .width       (cfg_width),
        .fs_act      (fs_act),
        .frame_start (frame_start)
    );

    assign fsync = fs_act ^ cfg_fs_invert;
endmodule

// File: rtl/audio_srg_chk.sv
module audio_srg_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic cfg_fs_invert,
    input logic cfg_err,
    input logic bclk,
    input logic fsync,
    input logic frame_start
);
    // R5: the strobe coincides with a rising bit clock
    assert_start_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (bclk && !$past(bclk)));

    // R5: the strobe never lasts two cycles
    assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R2, R4: a frame begins with the sync in its active level
    assert_start_sync_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (fsync != cfg_fs_invert));

    // R6: disabled for two edges means quiet outputs
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(enable) && !$past(enable, 2)) |-> (!bclk && !frame_start && fsync == cfg_fs_invert));

    // R7: an invalid configuration held for two edges gives no clock
    assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_err) && $past(cfg_err, 2)) |-> (!bclk && !frame_start));
endmodule

bind audio_srg audio_srg_chk u_audio_srg_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .cfg_fs_invert (cfg_fs_invert),
    .cfg_err       (cfg_err),
    .bclk          (bclk),
    .fsync         (fsync),
    .frame_start   (frame_start)
);

// File: tb/audio_srg_bench.sv
`timescale 1ns/1ps
module audio_srg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [7:0]  cfg_div = 8'd0;
    logic [11:0] cfg_period = 12'd3;
    logic [7:0]  cfg_width = 8'd1;
    logic [5:0]  cfg_word_bits = 6'd1;
    logic [3:0]  cfg_chans = 4'd1;
    logic        cfg_fs_invert = 1'b0;
    logic        bclk, fsync, frame_start, cfg_err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    audio_srg u_audio_srg (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_div(cfg_div), .cfg_period(cfg_period), .cfg_width(cfg_width),
        .cfg_word_bits(cfg_word_bits), .cfg_chans(cfg_chans),
        .cfg_fs_invert(cfg_fs_invert),
        .bclk(bclk), .fsync(fsync), .frame_start(frame_start), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Sweep one configuration: idle check, enable, predict every cycle.
    task automatic run_cfg(input int dv, input int per, input int wid, input int inv);
        int h, len;
        @(negedge clk);
        enable = 1'b0;
        cfg_div = 8'(dv); cfg_period = 12'(per); cfg_width = 8'(wid);
        cfg_fs_invert = inv[0]; cfg_word_bits = 6'd1; cfg_chans = 4'd1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R6 idle bclk", int'(bclk), 0);
        check("R6 idle fsync", int'(fsync), inv);
        check("R6 idle frame_start", int'(frame_start), 0);
        enable = 1'b1;
        @(posedge clk);
        h = dv + 1;
        len = 4 * h * (per + 1) + 3;
        for (int t = 1; t <= len; t++) begin
            int k, r, pos, fs_e, st_e;
            @(posedge clk); @(negedge clk);
            k = t / h;
            r = (k + 1) / 2;
            pos = (r >= 1) ? (r - 1) % (per + 1) : 0;
            fs_e = (r >= 1 && pos <= wid) ? 1 : 0;
            st_e = (k % 2 == 1 && t % h == 0 && pos == 0) ? 1 : 0;
            check("R1 bclk", int'(bclk), k % 2);
            if (wid == 0)
                check("R3 fsync one-bit", int'(fsync), fs_e ^ inv);
            else if (wid == (per + 1) / 2 - 1)
                check("R3 fsync half-frame", int'(fsync), fs_e ^ inv);
            else if (inv != 0)
                check("R4 fsync inverted", int'(fsync), fs_e ^ inv);
            else
                check("R2 fsync", int'(fsync), fs_e);
            check("R5 frame_start", int'(frame_start), st_e);
        end
        @(negedge clk);
        enable = 1'b0;
    endtask

    task automatic err_case(input int per, input int wid, input int bits, input int ch,
                            input int exp_err, input string req);
        int rises;
        @(negedge clk);
        enable = 1'b0;
        cfg_div = 8'd0; cfg_period = 12'(per); cfg_width = 8'(wid);
        cfg_word_bits = 6'(bits); cfg_chans = 4'(ch); cfg_fs_invert = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(req, int'(cfg_err), exp_err);
        enable = 1'b1;
        rises = 0;
        for (int t = 0; t < 40; t++) begin
            @(posedge clk); @(negedge clk);
            if (frame_start) rises++;
            if (exp_err != 0) check({req, " no bclk"}, int'(bclk), 0);
        end
        if (exp_err != 0) check({req, " no frame"}, rises, 0);
        else              check({req, " frames run"}, int'(rises > 0), 1);
        @(negedge clk);
        enable = 1'b0;
    endtask

    initial begin
        #1;
        check("R9 reset bclk", int'(bclk), 0);
        check("R9 reset fsync", int'(fsync), 0);
        check("R9 reset frame_start", int'(frame_start), 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int dv = 0; dv <= 2; dv++)
            for (int per = 1; per <= 5; per++)
                for (int wid = 0; wid < per; wid++)
                    for (int inv = 0; inv <= 1; inv++)
                        run_cfg(dv, per, wid, inv);

        // R6: a repeated configuration restarts from position 0
        run_cfg(1, 7, 3, 0);
        run_cfg(1, 7, 3, 0);

        err_case(5, 5, 1, 1, 1, "R7 width equals period");
        err_case(5, 9, 1, 1, 1, "R7 width above period");
        err_case(5, 4, 1, 1, 0, "R7 width one below period");
        err_case(15, 0, 16, 2, 1, "R8 frame too small");
        err_case(15, 0, 8, 2, 0, "R8 frame exactly fits");
        err_case(15, 7, 17, 1, 1, "R8 one bit short");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule